// File: doc/BRIEF.md
# Microwire Serial EEPROM Command Interface

This block is the slave-side serial front end of a word-organised non-volatile memory on a three-wire serial bus. The pins are chip select, serial clock, data in and data out. The block runs on a fast system clock and samples the serial clock as an ordinary synchronous input. A rising serial-clock edge counts only while chip select is high. Once a start bit arrives, the block shifts in a two-bit opcode and an address field, and for write-type commands a 16-bit data word.

Decoded commands update an internal register-file model of the array and the programming-enable state. Each decoded command is also offered to the surrounding logic as a valid/ready record. The record is held until it is accepted. A command that completes while the previous record is still unaccepted is not queued and is lost from the stream, but its effect on the array still takes place.

Reads shift stored words out on the data-out pin. A read can fetch a single word, or it can become a continuous stream of consecutive words for as long as the master keeps clocking. Protection policy and the timing of the programming cycle are handled by other blocks.

Top module: `mw_eeprom_if`

## Requirements
- R1: While waiting for an instruction, sampled 0 bits on DI are ignored. The first DI sample of 1 at a rising SK edge with CS high is the start bit.
- R2: After the start bit, the block takes a 2-bit opcode and then ADDR_W address bits, MSB first. The opcode encodings are: 10 read, 01 write, 00 extended. For extended commands the top two address bits select the command: 01 write-all, 11 program enable, 00 program disable. Opcode 11 and extended selector 10 are reserved: they change nothing and produce no command record.
- R3: A write takes 16 further data bits, MSB first. If programming is enabled, the word is stored at the address when the 16th bit is sampled. If programming is disabled, the stored word is unchanged.
- R4: A write-all takes 16 data bits. If programming is enabled, it stores them in every word. If programming is disabled, nothing changes.
- R5: After reset, programming is disabled. The enable command turns it on and the disable command turns it off.
- R6: For a read, the rising SK edge that samples the last address bit makes DO drive a 0 dummy bit with output enable 1. Each following rising edge presents the next data bit, MSB first. DO never changes without a rising SK edge while CS is high.
- R7: If clocking continues after the 16th data bit, the next word, at address plus one, follows at once with no dummy bit. The address wraps from the highest word back to word 0.
- R8: A read returns the stored contents whether programming is enabled or disabled.
- R9: If CS is low in a clock cycle, the next cycle has output enable 0. A partially shifted instruction is discarded, and the block waits for a new start bit.
- R10: Each completed command produces one record on the command stream with fields kind, address and data. The kind codes are 0 read, 1 write, 2 write-all, 3 enable, 4 disable. The data field is 0 for commands that carry no data. A record stays valid, with stable fields, until ready is high. A command that completes while a record is still held is dropped from the stream.
- R11: After reset, every stored word is 0, output enable is 0 and command valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, high active |
| sk | input | 1 | Serial clock, sampled by clk |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |
| do_oe | output | 1 | Data-out drive enable (0 means high impedance) |
| cmd_valid | output | 1 | Command record valid |
| cmd_ready | input | 1 | Command record accepted |
| cmd_kind | output | 3 | Command kind code |
| cmd_addr | output | ADDR_W | Address field of the command |
| cmd_data | output | 16 | Data field of the command |

## Verification
Writes to random addresses with random data, followed by single reads, tell apart a correct MSB-first capture from bit reversal or an off-by-one in the data counter. The dummy-bit check separates a correct read start from one that skips or repeats the first bit.

A long sequential read across the top address tells a correct wrap and dummy-free continuation from a stream that inserts a separator or stalls. Writes issued while programming is disabled, and a read of a known-zero word after a write-all, separate the enable gating from the address decode.

Leading zeros before the start bit, a frame aborted by dropping CS, the reserved opcodes, and a held record with ready low probe the framing and back-pressure rules.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    K_READ  = 3'd0,
    K_WRITE = 3'd1,
    K_WRALL = 3'd2,
    K_EN    = 3'd3,
    K_DIS   = 3'd4
  } cmd_kind_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_HDR,
    RX_DATA,
    RX_HOLD
  } rx_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_EXT   = 2'b00;

  localparam logic [1:0] EXT_WRALL = 2'b01;
  localparam logic [1:0] EXT_EN    = 2'b11;
  localparam logic [1:0] EXT_DIS   = 2'b00;

endpackage

// File: rtl/mw_rx_frame.sv
module mw_rx_frame
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rise,
  input  logic              di,
  output logic              ev_valid,
  output cmd_kind_e         ev_kind,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [WORD_W-1:0] ev_data,
  output logic              rd_start,
  output logic              wr_word,
  output logic              wr_all,
  output logic              set_en,
  output logic              clr_en
);

  localparam int HDR_W = 2 + ADDR_W;
  localparam int MAXB  = (HDR_W > WORD_W) ? HDR_W : WORD_W;
  localparam int CNT_W = $clog2(MAXB);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-2:0]  hdr;
  logic [WORD_W-2:0] dat;
  cmd_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;

  logic [HDR_W-1:0]  hdr_full;
  logic [WORD_W-1:0] dat_full;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr_in;
  logic [1:0]        ext_sel;
  logic              hdr_last;
  logic              dat_last;

  always_comb begin
    hdr_full = {hdr, di};
    dat_full = {dat, di};
    op       = hdr_full[HDR_W-1 -: 2];
    addr_in  = hdr_full[ADDR_W-1:0];
    ext_sel  = addr_in[ADDR_W-1 -: 2];
    hdr_last = (cnt == CNT_W'(HDR_W - 1));
    dat_last = (cnt == CNT_W'(WORD_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      hdr      <= '0;
      dat      <= '0;
      kind_q   <= K_READ;
      addr_q   <= '0;
      ev_valid <= 1'b0;
      ev_kind  <= K_READ;
      ev_addr  <= '0;
      ev_data  <= '0;
      rd_start <= 1'b0;
      wr_word  <= 1'b0;
      wr_all   <= 1'b0;
      set_en   <= 1'b0;
      clr_en   <= 1'b0;
    end else begin
      ev_valid <= 1'b0;
      rd_start <= 1'b0;
      wr_word  <= 1'b0;
      wr_all   <= 1'b0;
      set_en   <= 1'b0;
      clr_en   <= 1'b0;
      if (!cs) begin
        st <= RX_IDLE;
      end else if (rise) begin
        unique case (st)
          RX_IDLE: begin
            if (di) begin
              st  <= RX_HDR;
              cnt <= '0;
            end
          end
          RX_HDR: begin
            hdr <= hdr_full[HDR_W-2:0];
            cnt <= cnt + 1'b1;
            if (hdr_last) begin
              cnt    <= '0;
              addr_q <= addr_in;
              st     <= RX_HOLD;
              unique case (op)
                OP_READ: begin
                  rd_start <= 1'b1;
                  ev_valid <= 1'b1;
                  ev_kind  <= K_READ;
                  ev_addr  <= addr_in;
                  ev_data  <= '0;
                end
                OP_WRITE: begin
                  st     <= RX_DATA;
                  kind_q <= K_WRITE;
                end
                OP_EXT: begin
                  unique case (ext_sel)
                    EXT_WRALL: begin
                      st     <= RX_DATA;
                      kind_q <= K_WRALL;
                    end
                    EXT_EN: begin
                      set_en   <= 1'b1;
                      ev_valid <= 1'b1;
                      ev_kind  <= K_EN;
                      ev_addr  <= addr_in;
                      ev_data  <= '0;
                    end
                    EXT_DIS: begin
                      clr_en   <= 1'b1;
                      ev_valid <= 1'b1;
                      ev_kind  <= K_DIS;
                      ev_addr  <= addr_in;
                      ev_data  <= '0;
                    end
                    default: ;
                  endcase
                end
                default: ;
              endcase
            end
          end
          RX_DATA: begin
            dat <= dat_full[WORD_W-2:0];
            cnt <= cnt + 1'b1;
            if (dat_last) begin
              st       <= RX_HOLD;
              ev_valid <= 1'b1;
              ev_kind  <= kind_q;
              ev_addr  <= addr_q;
              ev_data  <= dat_full;
              wr_word  <= (kind_q == K_WRITE);
              wr_all   <= (kind_q == K_WRALL);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic              wr_word,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              prog_en;

  always_ff @(posedge clk) begin
    if (!rst_n)      prog_en <= 1'b0;
    else if (set_en) prog_en <= 1'b1;
    else if (clr_en) prog_en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (prog_en && (wr_all || (wr_word && wr_addr == ADDR_W'(i)))) begin
        mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mw_tx_serial.sv
module mw_tx_serial #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rise,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic              do_o,
  output logic              do_oe
);

  localparam int BIT_W = $clog2(WORD_W);

  logic              active;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] sh;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] nxt;
  logic              last_bit;

  assign nxt      = cur + 1'b1;
  assign rd_addr  = rd_start ? start_addr : nxt;
  assign last_bit = (bit_cnt == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !cs) begin
      active  <= 1'b0;
      do_oe   <= 1'b0;
      do_o    <= 1'b0;
      bit_cnt <= '0;
      sh      <= '0;
      cur     <= '0;
    end else if (rd_start) begin
      active  <= 1'b1;
      do_oe   <= 1'b1;
      do_o    <= 1'b0;
      bit_cnt <= '0;
      sh      <= rd_word;
      cur     <= start_addr;
    end else if (active && rise) begin
      do_o <= sh[WORD_W-1];
      if (last_bit) begin
        bit_cnt <= '0;
        cur     <= nxt;
        sh      <= rd_word;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        sh      <= {sh[WORD_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/mw_cmd_slot.sv
module mw_cmd_slot
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  cmd_kind_e         ev_kind,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [WORD_W-1:0] ev_data,
  input  logic              ready,
  output logic              valid,
  output cmd_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] data
);

  logic free;
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      kind  <= K_READ;
      addr  <= '0;
      data  <= '0;
    end else if (free) begin
      valid <= ev_valid;
      if (ev_valid) begin
        kind <= ev_kind;
        addr <= ev_addr;
        data <= ev_data;
      end
    end
  end

endmodule

// File: rtl/mw_eeprom_if.sv
module mw_eeprom_if
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  output logic              do_o,
  output logic              do_oe,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_data
);

  logic              sk_q;
  logic              rise;
  logic              ev_valid;
  cmd_kind_e         ev_kind;
  logic [ADDR_W-1:0] ev_addr;
  logic [WORD_W-1:0] ev_data;
  logic              rd_start;
  logic              wr_word;
  logic              wr_all;
  logic              set_en;
  logic              clr_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  cmd_kind_e         kind_o;

  always_ff @(posedge clk) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  assign rise = cs && sk && !sk_q;

  mw_rx_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rise(rise), .di(di),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .ev_data(ev_data), .rd_start(rd_start), .wr_word(wr_word),
    .wr_all(wr_all), .set_en(set_en), .clr_en(clr_en)
  );

  mw_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
    .wr_word(wr_word), .wr_all(wr_all), .wr_addr(ev_addr),
    .wr_data(ev_data), .rd_addr(rd_addr), .rd_data(rd_word)
  );

  mw_tx_serial #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rise(rise),
    .rd_start(rd_start), .start_addr(ev_addr), .rd_addr(rd_addr),
    .rd_word(rd_word), .do_o(do_o), .do_oe(do_oe)
  );

  mw_cmd_slot #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_addr(ev_addr), .ev_data(ev_data), .ready(cmd_ready),
    .valid(cmd_valid), .kind(kind_o), .addr(cmd_addr), .data(cmd_data)
  );

  assign cmd_kind = kind_o;

endmodule

// File: rtl/mw_eeprom_if_chk.sv
module mw_eeprom_if_chk #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              sk,
  input logic              do_o,
  input logic              do_oe,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [WORD_W-1:0] cmd_data
);

  logic sk_prev;
  logic edge_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) sk_prev <= 1'b0;
    else        sk_prev <= sk;
  end

  assign edge_seen = sk && !sk_prev;

  p_cs_low_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_oe);

  p_do_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !edge_seen) |=> $stable(do_o));

  p_dummy_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> !do_o);

  p_hold_record_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)
      && $stable(cmd_addr) && $stable(cmd_data)));

  p_kind_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind <= 3'd4));

endmodule

bind mw_eeprom_if mw_eeprom_if_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .do_o(do_o), .do_oe(do_oe),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data)
);

// File: tb/mw_eeprom_if_tb.sv
module mw_eeprom_if_tb;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic cmd_ready = 1'b1;
  logic do_o, do_oe, cmd_valid;
  logic [2:0] cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [15:0] cmd_data;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  logic last_do;
  logic last_oe;

  logic [15:0] model [DEPTH];
  bit en_m;

  always #2.5 clk = ~clk;

  mw_eeprom_if #(.ADDR_W(AW), .WORD_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk); di = v; sk = 1'b1;
    @(negedge clk);
    @(negedge clk); last_do = do_o; last_oe = do_oe; sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_frame();
    @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk); cs = 1'b1;
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = AW-1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_word(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
  endtask

  function automatic logic [AW-1:0] ext_addr(input logic [1:0] sel);
    return {sel, {(AW-2){1'b0}}};
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
    send_hdr(2'b01, a); send_word(d); end_frame();
    if (en_m) model[a] = d;
  endtask

  task automatic do_wrall(input logic [15:0] d);
    send_hdr(2'b00, ext_addr(2'b01)); send_word(d); end_frame();
    if (en_m) for (int i = 0; i < DEPTH; i++) model[i] = d;
  endtask

  task automatic do_en(input bit on);
    send_hdr(2'b00, ext_addr(on ? 2'b11 : 2'b00)); end_frame();
    en_m = on;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int nwords, input string req);
    logic [15:0] got;
    logic [AW-1:0] ea;
    send_hdr(2'b10, a);
    check(last_oe === 1'b1 && last_do === 1'b0, "R6 dummy bit", {last_oe, last_do}, 2'b10);
    for (int w = 0; w < nwords; w++) begin
      got = '0;
      for (int i = 15; i >= 0; i--) begin
        send_bit(1'b0);
        got[i] = last_do;
      end
      ea = a + AW'(w);
      check(got === model[ea], w == 0 ? req : "R7 sequential word", got, model[ea]);
    end
    end_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ra;
    logic [15:0] rd;
    logic [AW-1:0] used [8];
    void'($urandom(32'd7719));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    en_m = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(do_oe === 1'b0, "R11 oe after reset", do_oe, 0);
    check(cmd_valid === 1'b0, "R11 valid after reset", cmd_valid, 0);
    do_read(6'd5, 1, "R11 word zero after reset");

    // R3/R5: write while disabled leaves word unchanged
    do_write(6'd9, 16'hBEEF);
    do_read(6'd9, 1, "R3 write ignored while disabled");

    // R5 enable, then random writes and reads (R3, R6)
    do_en(1);
    for (int k = 0; k < 8; k++) begin
      ra = AW'($urandom_range(DEPTH-1));
      rd = 16'($urandom);
      used[k] = ra;
      do_write(ra, rd);
    end
    for (int k = 0; k < 8; k++) do_read(used[k], 1, "R3 random write readback");

    // directed patterns
    do_write(6'd0, 16'h8001);
    do_write(6'd63, 16'h7FFE);
    do_write(6'd62, 16'hA5C3);
    do_read(6'd0, 1, "R3 edge bits");

    // R7 sequential across top with wrap
    do_read(6'd62, 4, "R7 start word");

    // R1 leading zeros ignored
    @(negedge clk); cs = 1'b1;
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    check(last_oe === 1'b0, "R1 zeros before start", last_oe, 0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    for (int i = AW-1; i >= 0; i--) send_bit(ra[i]);
    check(last_oe === 1'b1 && last_do === 1'b0, "R1 read after leading zeros", {last_oe, last_do}, 2'b10);
    end_frame();

    // R9 abort mid data: word unchanged, oe low
    send_hdr(2'b01, 6'd62);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    end_frame();
    do_read(6'd62, 1, "R9 aborted write");
    send_hdr(2'b10, 6'd1);
    send_bit(1'b0);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); @(negedge clk);
    check(do_oe === 1'b0, "R9 oe after cs low", do_oe, 0);
    end_frame();

    // R2 reserved codes: no record, no change
    cmd_ready = 1'b0;
    send_hdr(2'b11, 6'd3); send_word(16'h1234); end_frame();
    send_hdr(2'b00, ext_addr(2'b10)); send_word(16'h1234); end_frame();
    check(cmd_valid === 1'b0, "R2 reserved codes no record", cmd_valid, 0);
    cmd_ready = 1'b1;
    do_read(6'd3, 1, "R2 reserved codes no change");

    // R10 record fields and hold
    cmd_ready = 1'b0;
    send_hdr(2'b01, 6'd17); send_word(16'hC0DE); end_frame();
    model[17] = 16'hC0DE;
    check(cmd_valid === 1'b1 && cmd_kind === 3'd1, "R10 write record kind", {cmd_valid, cmd_kind}, 4'b1001);
    check(cmd_addr === 6'd17 && cmd_data === 16'hC0DE, "R10 write record fields", {cmd_addr, cmd_data}, {6'd17, 16'hC0DE});
    do_en(0);
    check(cmd_kind === 3'd1 && cmd_data === 16'hC0DE, "R10 second record dropped", cmd_kind, 1);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk);
    check(cmd_valid === 1'b0, "R10 record released", cmd_valid, 0);

    // R8 read while disabled; R5 write after disable ignored
    do_read(6'd17, 1, "R8 read while disabled");
    do_write(6'd17, 16'h0000);
    do_read(6'd17, 1, "R5 write after disable");

    // R4 write-all disabled then enabled
    do_wrall(16'h5A5A);
    do_read(6'd40, 1, "R4 write-all while disabled");
    do_en(1);
    do_wrall(16'h3C96);
    do_read(6'd40, 1, "R4 write-all");
    do_read(6'd63, 2, "R4 write-all wrap");

    // read record
    cmd_ready = 1'b0;
    send_hdr(2'b10, 6'd33); end_frame();
    check(cmd_valid === 1'b1 && cmd_kind === 3'd0 && cmd_addr === 6'd33, "R10 read record", {cmd_kind, cmd_addr}, {3'd0, 6'd33});
    cmd_ready = 1'b1;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule